// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block collects streaming stores that should not be allocated into the main cache and sends them to memory as whole lines. Each store is a 16-byte beat with per-byte enables. Beats that target the same aligned 64-byte line are gathered into one of a few line-sized entries. When every byte of an entry has been written, the entry goes to memory at once as a single full-line write, with no read beforehand.

An entry that must leave while only some of its bytes are written is handled differently. This happens when it is evicted to make room, or when a fence drains the buffer. In that case the block first fetches the line from memory, lays the written bytes over the fetched data, and then writes the complete line back. After any line write, the cache is asked whether it holds that line. If it does, the same merged line is sent to the cache on a side port so the cached copy stays current. A line the cache does not hold is never pushed into it.

Memory and the cache are reached through simple valid/ready handshakes, and only one transaction is in flight at a time. A fence input drains every entry and reports completion with a one-cycle pulse.

Top module: `wc_store_buf`

## Requirements
- R1: After reset, no entry is valid. `mem_rd_valid`, `mem_wr_valid`, `cu_valid` and `fence_done` are low, and `st_ready` is high.
- R2: `st_addr` is a beat address. Its upper bits are the line tag, and its two low bits choose the 16-byte slot within the line. Store byte i with `st_be[i]` set lands at line byte slot*16+i. Beats that share a tag are gathered into one entry.
- R3: In the cycle after the store that completes all 64 bytes of an entry is accepted, `mem_wr_valid` rises. It carries the line address (low 6 bits zero) and the gathered data, and no read request is made for that line.
- R4: When a byte is written twice before its line leaves, the written line holds the later value.
- R5: An entry flushed with some bytes unwritten first issues a read for its line. In the cycle after the read data is accepted, it raises the write. The written line has fetched bytes where nothing was stored and stored bytes everywhere else.
- R6: If `cache_hit` is high in the cycle a line write is accepted, `cu_valid` rises in the next cycle with the same address and data. If `cache_hit` is low, no cache update follows.
- R7: The buffer has NUM_ENT entries (4 by default). A store to a new line while every entry is occupied is stalled with `st_ready` low. A round-robin victim, starting at entry 0, is flushed, and the store is then accepted.
- R8: A one-cycle `fence_req` flushes all valid entries in ascending index order, then pulses `fence_done` for exactly one cycle. If the buffer is already empty, `fence_done` is high two cycles after the cycle in which `fence_req` is high.
- R9: At most one of `mem_rd_valid`, `mem_wr_valid` and `cu_valid` is high at a time. A request that is not accepted stays high with its address unchanged.
- R10: `st_ready` is low while any flush is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store beat offered |
| st_ready | output | 1 | Store beat accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W-4 | Beat address: line tag over 2-bit slot |
| st_data | input | 128 | Store data, byte i at bits 8i+7:8i |
| st_be | input | 16 | Per-byte write enables |
| fence_req | input | 1 | Request to drain every entry |
| fence_done | output | 1 | One-cycle pulse once the buffer is empty after a fence |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | ADDR_W | Line address of the read |
| mem_rdata_valid | input | 1 | Fetched line is present |
| mem_rdata_ready | output | 1 | Block accepts the fetched line |
| mem_rdata | input | 512 | Fetched line data |
| mem_wr_valid | output | 1 | Full-line write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Line address of the write |
| mem_wr_data | output | 512 | Line data written |
| cu_valid | output | 1 | Update for a line the cache holds |
| cu_ready | input | 1 | Cache accepts the update |
| cu_addr | output | ADDR_W | Line address being flushed, also the cache lookup address |
| cu_data | output | 512 | Line data for the cached copy |
| cache_hit | input | 1 | Cache holds the line at cu_addr |

## Verification
Every result is due at a fixed cycle count, counted from the clock edge that accepts its cause. The full-line write is requested one cycle after the completing store. The merged write follows one cycle after the fill data is taken. The cache update follows one cycle after the line write is accepted. An empty fence answers two cycles after its request. The bench drives inputs and samples outputs on the falling edge, so it checks those outputs in exactly that cycle. A monitor logs every handshake with a cycle stamp, which lets the bench compare the order and the count of reads, writes and cache updates against expected sequences worked out by hand from the requirements. Stalls are shown by holding the memory write not-ready and by offering a fifth line to a full buffer. In both cases the bench confirms that the stalled request keeps waiting.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    typedef enum logic [2:0] {
        WS_IDLE  = 3'd0,
        WS_RDREQ = 3'd1,
        WS_RDDAT = 3'd2,
        WS_WR    = 3'd3,
        WS_CU    = 3'd4
    } wcb_state_e;
endpackage

// File: rtl/wcb_match.sv
// Tag lookup over all entries plus lowest-index free / valid search.
module wcb_match #(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 26,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_ENT-1:0]            vld,
    input  logic [NUM_ENT-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              look,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx,
    output logic                          any_free,
    output logic [IDX_W-1:0]              free_idx,
    output logic                          any_vld,
    output logic [IDX_W-1:0]              vld_idx
);
    logic [NUM_ENT-1:0] hvec;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
        assign hvec[e] = vld[e] && (tags[e] == look);
    end

    always_comb begin
        hit      = |hvec;
        any_free = ~&vld;
        any_vld  = |vld;
        hit_idx  = '0;
        free_idx = '0;
        vld_idx  = '0;
        // descending scan: the lowest index wins
        for (int e = NUM_ENT - 1; e >= 0; e--) begin
            if (hvec[e])  hit_idx  = IDX_W'(e);
            if (!vld[e])  free_idx = IDX_W'(e);
            if (vld[e])   vld_idx  = IDX_W'(e);
        end
    end
endmodule

// File: rtl/wcb_merge.sv
// Byte-wise select: take 'over' where mask is set, otherwise 'base'.
module wcb_merge #(
    parameter int LINE_B = 64
) (
    input  logic [LINE_B*8-1:0] base,
    input  logic [LINE_B*8-1:0] over,
    input  logic [LINE_B-1:0]   mask,
    output logic [LINE_B*8-1:0] line
);
    for (genvar b = 0; b < LINE_B; b++) begin : g_byte
        assign line[b*8 +: 8] = mask[b] ? over[b*8 +: 8] : base[b*8 +: 8];
    end
endmodule

// File: rtl/wc_store_buf.sv
module wc_store_buf
    import wcb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_ENT = 4,
    parameter int LINE_B  = 64,
    parameter int BEAT_B  = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               st_valid,
    output logic                               st_ready,
    input  logic [ADDR_W-$clog2(BEAT_B)-1:0]   st_addr,
    input  logic [BEAT_B*8-1:0]                st_data,
    input  logic [BEAT_B-1:0]                  st_be,
    input  logic                               fence_req,
    output logic                               fence_done,
    output logic                               mem_rd_valid,
    input  logic                               mem_rd_ready,
    output logic [ADDR_W-1:0]                  mem_rd_addr,
    input  logic                               mem_rdata_valid,
    output logic                               mem_rdata_ready,
    input  logic [LINE_B*8-1:0]                mem_rdata,
    output logic                               mem_wr_valid,
    input  logic                               mem_wr_ready,
    output logic [ADDR_W-1:0]                  mem_wr_addr,
    output logic [LINE_B*8-1:0]                mem_wr_data,
    output logic                               cu_valid,
    input  logic                               cu_ready,
    output logic [ADDR_W-1:0]                  cu_addr,
    output logic [LINE_B*8-1:0]                cu_data,
    input  logic                               cache_hit
);
    localparam int LINE_W = LINE_B * 8;
    localparam int OFF_W  = $clog2(LINE_B);
    localparam int BOFF_W = $clog2(BEAT_B);
    localparam int SLOT_W = OFF_W - BOFF_W;
    localparam int NBEAT  = LINE_B / BEAT_B;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    typedef struct packed {
        wcb_state_e                         st;
        logic [NUM_ENT-1:0]                 vld;
        logic [NUM_ENT-1:0][TAG_W-1:0]      tag;
        logic [NUM_ENT-1:0][LINE_B-1:0]     bv;
        logic [NUM_ENT-1:0][LINE_W-1:0]     dat;
        logic [IDX_W-1:0]                   fidx;
        logic [IDX_W-1:0]                   rr;
        logic                               fence;
        logic                               done;
    } regs_t;

    regs_t d, q;

    // store-side decode
    logic [SLOT_W-1:0] st_slot;
    logic [TAG_W-1:0]  st_tag;
    logic [LINE_B-1:0] st_mask;
    logic [LINE_W-1:0] st_rep;
    assign st_slot = st_addr[SLOT_W-1:0];
    assign st_tag  = st_addr[ADDR_W-BOFF_W-1:SLOT_W];
    assign st_mask = {{(LINE_B-BEAT_B){1'b0}}, st_be} << (BEAT_B * int'(st_slot));
    assign st_rep  = {NBEAT{st_data}};

    logic             m_hit, m_any_free, m_any_vld;
    logic [IDX_W-1:0] m_hit_idx, m_free_idx, m_vld_idx;

    wcb_match #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
        .vld      (q.vld),
        .tags     (q.tag),
        .look     (st_tag),
        .hit      (m_hit),
        .hit_idx  (m_hit_idx),
        .any_free (m_any_free),
        .free_idx (m_free_idx),
        .any_vld  (m_any_vld),
        .vld_idx  (m_vld_idx)
    );

    logic [IDX_W-1:0]  sel_idx;
    logic [LINE_W-1:0] st_line;
    logic [LINE_B-1:0] st_bv;
    assign sel_idx = m_hit ? m_hit_idx : m_free_idx;
    assign st_bv   = q.bv[sel_idx] | st_mask;

    wcb_merge #(.LINE_B(LINE_B)) u_merge_st (
        .base (q.dat[sel_idx]),
        .over (st_rep),
        .mask (st_mask),
        .line (st_line)
    );

    logic [LINE_W-1:0] fill_line;
    wcb_merge #(.LINE_B(LINE_B)) u_merge_fill (
        .base (mem_rdata),
        .over (q.dat[q.fidx]),
        .mask (q.bv[q.fidx]),
        .line (fill_line)
    );

    // flush-side address and data
    logic [ADDR_W-1:0] f_addr;
    assign f_addr      = {q.tag[q.fidx], {OFF_W{1'b0}}};
    assign mem_rd_addr = f_addr;
    assign mem_wr_addr = f_addr;
    assign cu_addr     = f_addr;
    assign mem_wr_data = q.dat[q.fidx];
    assign cu_data     = q.dat[q.fidx];
    assign fence_done  = q.done;

    always_comb begin
        d               = q;
        d.done          = 1'b0;
        st_ready        = 1'b0;
        mem_rd_valid    = 1'b0;
        mem_rdata_ready = 1'b0;
        mem_wr_valid    = 1'b0;
        cu_valid        = 1'b0;

        unique case (q.st)
            WS_IDLE: begin
                if (q.fence) begin
                    if (m_any_vld) begin
                        d.fidx = m_vld_idx;
                        d.st   = (&q.bv[m_vld_idx]) ? WS_WR : WS_RDREQ;
                    end else begin
                        d.fence = 1'b0;
                        d.done  = 1'b1;
                    end
                end else if (m_hit || m_any_free) begin
                    st_ready = 1'b1;
                    if (st_valid) begin
                        d.vld[sel_idx] = 1'b1;
                        d.tag[sel_idx] = st_tag;
                        d.bv[sel_idx]  = st_bv;
                        d.dat[sel_idx] = st_line;
                        if (&st_bv) begin
                            d.fidx = sel_idx;
                            d.st   = WS_WR;
                        end
                    end
                end else if (st_valid) begin
                    // no room: evict the round-robin victim, store waits
                    d.fidx = q.rr;
                    d.rr   = (q.rr == IDX_W'(NUM_ENT - 1)) ? '0 : q.rr + 1'b1;
                    d.st   = (&q.bv[q.rr]) ? WS_WR : WS_RDREQ;
                end
            end
            WS_RDREQ: begin
                mem_rd_valid = 1'b1;
                if (mem_rd_ready) d.st = WS_RDDAT;
            end
            WS_RDDAT: begin
                mem_rdata_ready = 1'b1;
                if (mem_rdata_valid) begin
                    d.dat[q.fidx] = fill_line;
                    d.bv[q.fidx]  = '1;
                    d.st          = WS_WR;
                end
            end
            WS_WR: begin
                mem_wr_valid = 1'b1;
                if (mem_wr_ready) begin
                    if (cache_hit) begin
                        d.st = WS_CU;
                    end else begin
                        d.vld[q.fidx] = 1'b0;
                        d.bv[q.fidx]  = '0;
                        d.st          = WS_IDLE;
                    end
                end
            end
            WS_CU: begin
                cu_valid = 1'b1;
                if (cu_ready) begin
                    d.vld[q.fidx] = 1'b0;
                    d.bv[q.fidx]  = '0;
                    d.st          = WS_IDLE;
                end
            end
            default: d.st = WS_IDLE;
        endcase

        if (fence_req) d.fence = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wcb_checker.sv
module wcb_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_ready,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic              mem_rdata_valid,
    input logic              mem_rdata_ready,
    input logic              mem_wr_valid,
    input logic              mem_wr_ready,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              cu_valid,
    input logic              cache_hit,
    input logic              fence_done
);
    AST_ONE_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_valid, mem_wr_valid, cu_valid})); // R9
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr)); // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid); // R9
    AST_FILL_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rdata_valid && mem_rdata_ready |=> mem_wr_valid); // R5
    AST_CU_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cu_valid) |-> $past(mem_wr_valid && mem_wr_ready && cache_hit)); // R6
    AST_NO_CU_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && mem_wr_ready && !cache_hit |=> !cu_valid); // R6
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || mem_rdata_ready || mem_wr_valid || cu_valid) |-> !st_ready); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |=> !fence_done); // R8
endmodule

bind wc_store_buf wcb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .st_ready        (st_ready),
    .mem_rd_valid    (mem_rd_valid),
    .mem_rd_ready    (mem_rd_ready),
    .mem_rdata_valid (mem_rdata_valid),
    .mem_rdata_ready (mem_rdata_ready),
    .mem_wr_valid    (mem_wr_valid),
    .mem_wr_ready    (mem_wr_ready),
    .mem_wr_addr     (mem_wr_addr),
    .cu_valid        (cu_valid),
    .cache_hit       (cache_hit),
    .fence_done      (fence_done)
);

// File: tb/wc_store_buf_tb.sv
module wc_store_buf_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         st_valid;
    logic         st_ready;
    logic [27:0]  st_addr;
    logic [127:0] st_data;
    logic [15:0]  st_be;
    logic         fence_req;
    logic         fence_done;
    logic         mem_rd_valid, mem_rd_ready;
    logic [31:0]  mem_rd_addr;
    logic         mem_rdata_valid, mem_rdata_ready;
    logic [511:0] mem_rdata;
    logic         mem_wr_valid, mem_wr_ready;
    logic [31:0]  mem_wr_addr;
    logic [511:0] mem_wr_data;
    logic         cu_valid, cu_ready;
    logic [31:0]  cu_addr;
    logic [511:0] cu_data;
    logic         cache_hit;

    always #(CLK_PERIOD/2) clk = ~clk;

    wc_store_buf dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be),
        .fence_req(fence_req), .fence_done(fence_done),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rdata_valid(mem_rdata_valid), .mem_rdata_ready(mem_rdata_ready), .mem_rdata(mem_rdata),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data),
        .cu_valid(cu_valid), .cu_ready(cu_ready), .cu_addr(cu_addr), .cu_data(cu_data),
        .cache_hit(cache_hit)
    );

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;
    int rd_cnt = 0, wr_cnt = 0, cu_cnt = 0, done_cnt = 0;
    int rd_cyc = 0, wr_cyc = 0;
    logic [31:0]  rd_addr_last, cu_addr_last;
    logic [511:0] wr_data_last, cu_data_last;
    logic [31:0]  wr_log [0:31];

    function automatic logic [511:0] mem_pat(input logic [31:0] a);
        logic [511:0] r;
        for (int i = 0; i < 64; i++) r[i*8 +: 8] = a[13:6] + 8'(i) * 8'd3;
        return r;
    endfunction

    function automatic logic [127:0] beat(input int n);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = 8'(n * 16 + i);
        return r;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // memory / cache model and handshake monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rdata_valid <= 1'b0;
            mem_rdata       <= '0;
        end else begin
            if (mem_rdata_valid && mem_rdata_ready) mem_rdata_valid <= 1'b0;
            if (mem_rd_valid && mem_rd_ready) begin
                mem_rdata_valid <= 1'b1;
                mem_rdata       <= mem_pat(mem_rd_addr);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_rd_valid && mem_rd_ready) begin
                rd_cnt++; rd_addr_last = mem_rd_addr; rd_cyc = cyc;
            end
            if (mem_wr_valid && mem_wr_ready) begin
                wr_log[wr_cnt % 32] = mem_wr_addr;
                wr_cnt++; wr_data_last = mem_wr_data; wr_cyc = cyc;
            end
            if (cu_valid && cu_ready) begin
                cu_cnt++; cu_addr_last = cu_addr; cu_data_last = cu_data;
            end
            if (fence_done) done_cnt++;
        end
        if (cyc == WD_LIMIT) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [127:0] dt, input logic [15:0] be);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a[31:4]; st_data = dt; st_be = be;
        while (!st_ready) @(negedge clk);
        @(posedge clk);
        #1 st_valid = 1'b0;
    endtask

    task automatic pulse_fence();
        @(negedge clk); fence_req = 1'b1;
        @(negedge clk); fence_req = 1'b0;
    endtask

    task automatic wait_done(input int prev);
        for (int i = 0; i < 300 && done_cnt == prev; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 rd_valid", 512'(mem_rd_valid), 512'(0));
        check("R1 wr_valid", 512'(mem_wr_valid), 512'(0));
        check("R1 cu_valid", 512'(cu_valid), 512'(0));
        check("R1 fence_done", 512'(fence_done), 512'(0));
        check("R1 st_ready", 512'(st_ready), 512'(1));
    endtask

    task automatic t_full_line();
        int w0 = wr_cnt, r0 = rd_cnt, c0 = cu_cnt;
        logic [511:0] exp;
        mem_wr_ready = 1'b0;
        for (int s = 0; s < 4; s++) begin
            do_store(32'h1000 + 32'(s * 16), beat(s), 16'hFFFF);
            exp[s*128 +: 128] = beat(s);
        end
        @(negedge clk);
        check("R3 wr_valid next cycle", 512'(mem_wr_valid), 512'(1));
        check("R3 wr_addr", 512'(mem_wr_addr), 512'(32'h1000));
        check("R10 st_ready low in flush", 512'(st_ready), 512'(0));
        repeat (2) @(negedge clk);
        check("R9 wr held", 512'(mem_wr_valid), 512'(1));
        check("R9 no early wr", 512'(wr_cnt), 512'(w0));
        mem_wr_ready = 1'b1;
        @(negedge clk);
        check("R3 one write", 512'(wr_cnt), 512'(w0 + 1));
        check("R2 gathered data", wr_data_last, exp);
        check("R3 no read", 512'(rd_cnt), 512'(r0));
        check("R6 no cache update on miss", 512'(cu_cnt), 512'(c0));
    endtask

    task automatic t_overwrite();
        int w0 = wr_cnt;
        logic [511:0] exp;
        do_store(32'h2060, beat(5), 16'hFFFF);
        do_store(32'h2040, beat(6), 16'hFFFF);
        do_store(32'h2040, beat(7), 16'h00FF);
        do_store(32'h2050, beat(8), 16'hFFFF);
        do_store(32'h2070, beat(9), 16'hFFFF);
        exp[0 +: 64]    = beat(7)[63:0];
        exp[64 +: 64]   = beat(6)[127:64];
        exp[128 +: 128] = beat(8);
        exp[256 +: 128] = beat(5);
        exp[384 +: 128] = beat(9);
        repeat (2) @(negedge clk);
        check("R4 write count", 512'(wr_cnt), 512'(w0 + 1));
        check("R4 latest byte wins", wr_data_last, exp);
        check("R2 line address", 512'(wr_log[w0 % 32]), 512'(32'h2040));
    endtask

    task automatic t_partial_hit();
        int w0 = wr_cnt, r0 = rd_cnt, c0 = cu_cnt, d0 = done_cnt;
        logic [511:0] exp;
        logic [127:0] b;
        b   = beat(10);
        exp = mem_pat(32'h3000);
        for (int i = 0; i < 16; i++)
            if (i % 8 < 4) exp[(16 + i)*8 +: 8] = b[i*8 +: 8];
        do_store(32'h3010, b, 16'h0F0F);
        cache_hit = 1'b1;
        pulse_fence();
        wait_done(d0);
        cache_hit = 1'b0;
        check("R5 one read", 512'(rd_cnt), 512'(r0 + 1));
        check("R5 read addr", 512'(rd_addr_last), 512'(32'h3000));
        check("R5 read before write", 512'(rd_cyc < wr_cyc), 512'(1));
        check("R5 merged line", wr_data_last, exp);
        check("R6 cache updated", 512'(cu_cnt), 512'(c0 + 1));
        check("R6 cache data", cu_data_last, exp);
        check("R6 cache addr", 512'(cu_addr_last), 512'(32'h3000));
        check("R8 fence wrote", 512'(wr_cnt), 512'(w0 + 1));
    endtask

    task automatic t_evict();
        int w0 = wr_cnt, r0 = rd_cnt, d0;
        for (int k = 0; k < 4; k++) do_store(32'h4000 + 32'(k * 64), beat(20 + k), 16'h0001);
        @(negedge clk);
        st_valid = 1'b1; st_addr = 28'h0004100 >> 4; st_data = beat(30); st_be = 16'h0001;
        #1;
        check("R7 stall when full", 512'(st_ready), 512'(0));
        while (!st_ready) @(negedge clk);
        @(posedge clk);
        #1 st_valid = 1'b0;
        check("R7 victim is entry 0", 512'(wr_log[w0 % 32]), 512'(32'h4000));
        check("R7 single eviction", 512'(wr_cnt), 512'(w0 + 1));
        d0 = done_cnt;
        pulse_fence();
        wait_done(d0);
        check("R8 order 0", 512'(wr_log[(w0 + 1) % 32]), 512'(32'h4100));
        check("R8 order 1", 512'(wr_log[(w0 + 2) % 32]), 512'(32'h4040));
        check("R8 order 2", 512'(wr_log[(w0 + 3) % 32]), 512'(32'h4080));
        check("R8 order 3", 512'(wr_log[(w0 + 4) % 32]), 512'(32'h40C0));
        check("R5 reads for partial lines", 512'(rd_cnt), 512'(r0 + 5));
    endtask

    task automatic t_empty_fence();
        int w0 = wr_cnt;
        @(negedge clk); fence_req = 1'b1;
        @(negedge clk); fence_req = 1'b0;
        @(negedge clk);
        check("R8 empty fence done", 512'(fence_done), 512'(1));
        @(negedge clk);
        check("R8 done one cycle", 512'(fence_done), 512'(0));
        check("R8 empty fence no write", 512'(wr_cnt), 512'(w0));
    endtask

    initial begin
        rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
        fence_req = 1'b0; mem_rd_ready = 1'b1; mem_wr_ready = 1'b1;
        cu_ready = 1'b1; cache_hit = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_full_line();
        t_overwrite();
        t_partial_hit();
        t_evict();
        t_empty_fence();
        summary();
        $finish;
    end
endmodule